// File: doc/BRIEF.md
# Bus Master Interface Unit for a 32-bit Pipelined-Handshake Bus

This unit takes one memory request at a time from a processor core and runs it as one or more Wishbone B.3 master cycles on a 32-bit, byte-granular data port with big-endian lane order. A request carries a kind (read, write, test-and-set, interrupt acknowledge), an operand size (byte, word or long), a byte address and, for writes, a right-justified operand. The unit derives the byte selects and places or extracts data on the byte lanes. An operand that crosses a 32-bit boundary is split into two beats. A test-and-set runs as a locked read followed by a write. An interrupt acknowledge is marked by its own cycle tag.

Each accepted request ends with exactly one response pulse that carries a status code and the read result. The bus termination inputs mean different things depending on the cycle. On a memory access an error becomes a bus-error status, and a retry makes the unit repeat the beat without telling the core. On an interrupt acknowledge an error means a spurious interrupt and a retry means that an autovector is needed. If the core sets the hold flag, the bus cycle stays open after a response, so the next request continues as part of a block transfer.

The controller has four states. IDLE: no cycle open, requests accepted. ACCESS: strobe asserted for the current beat. RETRY: cycle held with strobe low for one clock after a retry. HOLD: cycle held with strobe low after a held response, requests accepted. The transitions are:
- IDLE→ACCESS on a request.
- ACCESS→ACCESS on an acknowledge that moves to the second split beat or to the test-and-set write.
- ACCESS→RETRY on a memory retry.
- ACCESS→HOLD on the final acknowledge of a held read or write.
- ACCESS→IDLE on any other ending.
- RETRY→ACCESS always.
- HOLD→ACCESS on a request.
- HOLD→IDLE when no request is present.

Top module: `wbm_biu`

## Requirements
- R1: Byte lanes are big-endian. Byte address offset 0 sits on DAT[31:24] with SEL[3], and offset 3 on DAT[7:0] with SEL[0]. An access that does not cross a 32-bit boundary runs as one beat whose select bits cover exactly the operand bytes. Its word address is the byte address bits [31:2].
- R2: A word at offset 3, or a long at offset 1, 2 or 3, runs as two beats. The second beat uses the next word address. The read result is the operand bytes merged in address order and right-justified in rsp_rdata.
- R3: For a write, the operand is taken right-justified from req_wdata. Its most significant byte goes to the lowest byte address, and write enable is high on every beat.
- R4: An error on a read or write beat ends the request with status 1 (bus error). The cycle and the strobe are low in the following clock, even when hold was requested.
- R5: A retry on a memory beat gives one clock with the cycle high, the strobe low and no response. Then the same beat is issued again.
- R6: An interrupt acknowledge (kind 3) carries cycle tag 2. Its word address is all ones with the level req_addr[2:0] in the low three bits, its select is 0001, and write enable is low. On acknowledge it returns status 0 with the vector DAT_I[7:0] zero-extended.
- R7: An error on an interrupt acknowledge returns status 2 (spurious). A retry on an interrupt acknowledge returns status 3 (autovector).
- R8: A test-and-set (kind 2) carries cycle tag 1 and performs two beats at the same byte address. First a byte read, then a byte write of that value with bit 7 set. Lock stays high from the read strobe until the write ends, and the response returns the original byte.
- R9: When req_hold is set on a read or write that completes normally, the cycle stays high with the strobe low for one clock. A request offered in that clock continues without dropping the cycle; otherwise the cycle drops in the next clock.
- R10: Every accepted request produces exactly one single-clock response pulse, after a terminating input. The cycle is held high from acceptance until the response.
- R11: After reset the cycle, strobe, lock and response are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Unit can accept a request this clock |
| req_kind | input | 2 | 0 read, 1 write, 2 test-and-set, 3 interrupt acknowledge |
| req_size | input | 2 | 0 byte, 1 word, 2 long |
| req_addr | input | AW | Byte address, or level in bits [2:0] for an acknowledge |
| req_wdata | input | 32 | Right-justified write operand |
| req_hold | input | 1 | Keep the bus cycle open after this response |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_status | output | 2 | 0 ok, 1 bus error, 2 spurious, 3 autovector |
| rsp_rdata | output | 32 | Right-justified read result or vector |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_we_o | output | 1 | Write enable |
| wb_lock_o | output | 1 | Locked sequence |
| wb_tag_o | output | 2 | Cycle tag: 0 memory, 1 read-modify-write, 2 interrupt acknowledge |
| wb_adr_o | output | AW-2 | Word address |
| wb_sel_o | output | 4 | Byte selects |
| wb_dat_o | output | 32 | Write data |
| wb_dat_i | input | 32 | Read data |
| wb_ack_i | input | 1 | Normal termination |
| wb_err_i | input | 1 | Error termination |
| wb_rty_i | input | 1 | Retry termination |

## Verification
The bench targets boundary-crossing operands at every offset. A unit that mis-shifts the lanes would put bytes on the wrong selects or merge the halves in the wrong order, and a missing split would leave the tail bytes unread. It injects retries and errors on first beats, second beats and the write half of a test-and-set. It would catch a retry leaking out as a response, lock dropping between the read and the write, or an error reported with the memory meaning on an interrupt acknowledge. Held block sequences are run back to back, so a controller that drops the cycle between beats, or keeps it open when no request follows, shows up on the cycle output.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int DW     = LANE_W * LANES;
    localparam int OFF_W  = $clog2(LANES);
    localparam int NB_W   = OFF_W + 1;
    localparam int SH_W   = NB_W + 1;
    localparam int LVL_W  = 3;

    typedef enum logic [1:0] {KIND_RD = 2'd0, KIND_WR = 2'd1, KIND_TAS = 2'd2, KIND_IACK = 2'd3} kind_e;
    typedef enum logic [1:0] {RS_OK = 2'd0, RS_BUSERR = 2'd1, RS_SPURIOUS = 2'd2, RS_AUTOVEC = 2'd3} status_e;
    typedef enum logic [1:0] {TAG_MEM = 2'd0, TAG_RMW = 2'd1, TAG_IACK = 2'd2, TAG_RSVD = 2'd3} tag_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ACCESS = 2'd1, ST_RETRY = 2'd2, ST_HOLD = 2'd3} fsm_e;

    // operand size code to byte count
    function automatic logic [NB_W-1:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    size_bytes = NB_W'(1);
            2'd1:    size_bytes = NB_W'(2);
            default: size_bytes = NB_W'(LANES);
        endcase
    endfunction

    // lanes between the operand's last byte and the end of a two-word window
    function automatic logic [SH_W-1:0] lane_shift(input logic [OFF_W-1:0] off, input logic [NB_W-1:0] nb);
        lane_shift = SH_W'(2 * LANES) - SH_W'(off) - SH_W'(nb);
    endfunction
endpackage

// File: rtl/wbm_lane_map.sv
module wbm_lane_map
    import wbm_pkg::*;
(
    input  logic [OFF_W-1:0] off_i,
    input  logic [NB_W-1:0]  nb_i,
    input  logic [DW-1:0]    data_i,
    output logic [LANES-1:0] sel0_o,
    output logic [LANES-1:0] sel1_o,
    output logic [DW-1:0]    dat0_o,
    output logic [DW-1:0]    dat1_o,
    output logic             split_o
);
    localparam int WL = 2 * LANES;

    logic [SH_W-1:0]   sh;
    logic [WL-1:0]     mask2;
    logic [DW-1:0]     masked;
    logic [2*DW-1:0]   win;

    // keep only the operand bytes of the right-justified value
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign masked[g*LANE_W +: LANE_W] = (NB_W'(g) < nb_i) ? data_i[g*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        sh      = lane_shift(off_i, nb_i);
        mask2   = ((WL'(1) << nb_i) - WL'(1)) << sh;
        win     = {{DW{1'b0}}, masked} << (32'(sh) * LANE_W);
        sel0_o  = mask2[WL-1:LANES];
        sel1_o  = mask2[LANES-1:0];
        dat0_o  = win[2*DW-1:DW];
        dat1_o  = win[DW-1:0];
        split_o = |mask2[LANES-1:0];
    end

    always_comb begin
        assert_lane_count_R1: assert ($countones(mask2) == 32'(nb_i))
            else $error("select count differs from operand size");
    end
endmodule

// File: rtl/wbm_rd_align.sv
module wbm_rd_align
    import wbm_pkg::*;
(
    input  logic [2*DW-1:0]  win_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [NB_W-1:0]  nb_i,
    output logic [DW-1:0]    val_o
);
    logic [SH_W-1:0] sh;
    logic [DW-1:0]   low;

    always_comb begin
        sh  = lane_shift(off_i, nb_i);
        low = DW'(win_i >> (32'(sh) * LANE_W));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_keep
        assign val_o[g*LANE_W +: LANE_W] = (NB_W'(g) < nb_i) ? low[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/wbm_biu.sv
module wbm_biu
    import wbm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_kind,
    input  logic [1:0]          req_size,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    input  logic                req_hold,
    output logic                rsp_valid,
    output logic [1:0]          rsp_status,
    output logic [DW-1:0]       rsp_rdata,
    output logic                wb_cyc_o,
    output logic                wb_stb_o,
    output logic                wb_we_o,
    output logic                wb_lock_o,
    output logic [1:0]          wb_tag_o,
    output logic [AW-3:0]       wb_adr_o,
    output logic [LANES-1:0]    wb_sel_o,
    output logic [DW-1:0]       wb_dat_o,
    input  logic [DW-1:0]       wb_dat_i,
    input  logic                wb_ack_i,
    input  logic                wb_err_i,
    input  logic                wb_rty_i
);
    localparam int WA = AW - 2;

    fsm_e               state_q, state_d;
    kind_e              kind_q, kind_in;
    logic [NB_W-1:0]    nb_q;
    logic [OFF_W-1:0]   off_q;
    logic [WA-1:0]      word_q;
    logic [DW-1:0]      wdata_q, rhi_q;
    logic [LANE_W-1:0]  tas_old_q;
    logic               hold_q, beat_q, tasw_q;

    logic [LANES-1:0]   sel0, sel1;
    logic [DW-1:0]      dat0, dat1, rd_val;
    logic [2*DW-1:0]    win_now;
    logic               split, accept;

    logic               fin, go_beat1, go_tasw;
    status_e            fin_st;
    logic [DW-1:0]      fin_dat;

    assign kind_in = kind_e'(req_kind);
    assign accept  = req_valid && req_ready;

    wbm_lane_map u_lane (
        .off_i  (off_q),
        .nb_i   (nb_q),
        .data_i (wdata_q),
        .sel0_o (sel0),
        .sel1_o (sel1),
        .dat0_o (dat0),
        .dat1_o (dat1),
        .split_o(split)
    );

    assign win_now = beat_q ? {rhi_q, wb_dat_i} : {wb_dat_i, {DW{1'b0}}};

    wbm_rd_align u_rd (
        .win_i (win_now),
        .off_i (off_q),
        .nb_i  (nb_q),
        .val_o (rd_val)
    );

    // next state and termination classification
    always_comb begin
        state_d  = state_q;
        fin      = 1'b0;
        fin_st   = RS_OK;
        fin_dat  = '0;
        go_beat1 = 1'b0;
        go_tasw  = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ACCESS;
            ST_HOLD:  state_d = req_valid ? ST_ACCESS : ST_IDLE;
            ST_RETRY: state_d = ST_ACCESS;
            ST_ACCESS: begin
                if (wb_err_i) begin
                    fin     = 1'b1;
                    fin_st  = (kind_q == KIND_IACK) ? RS_SPURIOUS : RS_BUSERR;
                    state_d = ST_IDLE;
                end else if (wb_rty_i) begin
                    if (kind_q == KIND_IACK) begin
                        fin     = 1'b1;
                        fin_st  = RS_AUTOVEC;
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_RETRY;
                    end
                end else if (wb_ack_i) begin
                    if (kind_q == KIND_IACK) begin
                        fin     = 1'b1;
                        fin_dat = DW'(wb_dat_i[LANE_W-1:0]);
                        state_d = ST_IDLE;
                    end else if (!beat_q && split) begin
                        go_beat1 = 1'b1;
                    end else if (kind_q == KIND_TAS && !tasw_q) begin
                        go_tasw = 1'b1;
                    end else begin
                        fin     = 1'b1;
                        if (kind_q == KIND_RD) fin_dat = rd_val;
                        else if (kind_q == KIND_TAS) fin_dat = DW'(tas_old_q);
                        state_d = hold_q ? ST_HOLD : ST_IDLE;
                    end
                end
            end
        endcase
    end

    // state and request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            kind_q     <= KIND_RD;
            nb_q       <= NB_W'(1);
            off_q      <= '0;
            word_q     <= '0;
            wdata_q    <= '0;
            rhi_q      <= '0;
            tas_old_q  <= '0;
            hold_q     <= 1'b0;
            beat_q     <= 1'b0;
            tasw_q     <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_status <= RS_OK;
            rsp_rdata  <= '0;
        end else begin
            state_q   <= state_d;
            rsp_valid <= fin;
            if (fin) begin
                rsp_status <= fin_st;
                rsp_rdata  <= fin_dat;
            end
            if (accept) begin
                kind_q  <= kind_in;
                nb_q    <= (kind_in == KIND_TAS || kind_in == KIND_IACK) ? NB_W'(1) : size_bytes(req_size);
                off_q   <= (kind_in == KIND_IACK) ? '0 : req_addr[OFF_W-1:0];
                word_q  <= (kind_in == KIND_IACK) ? {{(WA-LVL_W){1'b1}}, req_addr[LVL_W-1:0]}
                                                  : req_addr[AW-1:2];
                wdata_q <= req_wdata;
                hold_q  <= req_hold && (kind_in == KIND_RD || kind_in == KIND_WR);
                beat_q  <= 1'b0;
                tasw_q  <= 1'b0;
            end
            if (go_beat1) begin
                beat_q <= 1'b1;
                rhi_q  <= wb_dat_i;
            end
            if (go_tasw) begin
                tasw_q    <= 1'b1;
                tas_old_q <= rd_val[LANE_W-1:0];
                wdata_q   <= DW'(rd_val[LANE_W-1:0] | 8'h80);
            end
        end
    end

    // bus and handshake outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE) || (state_q == ST_HOLD);
        wb_cyc_o  = (state_q != ST_IDLE);
        wb_stb_o  = (state_q == ST_ACCESS);
        wb_we_o   = (kind_q == KIND_WR) || (kind_q == KIND_TAS && tasw_q);
        wb_lock_o = (kind_q == KIND_TAS) && (state_q == ST_ACCESS || state_q == ST_RETRY);
        unique case (kind_q)
            KIND_TAS:  wb_tag_o = TAG_RMW;
            KIND_IACK: wb_tag_o = TAG_IACK;
            default:   wb_tag_o = TAG_MEM;
        endcase
        if (kind_q == KIND_IACK) begin
            wb_adr_o = word_q;
            wb_sel_o = LANES'(1);
        end else begin
            wb_adr_o = beat_q ? word_q + WA'(1) : word_q;
            wb_sel_o = beat_q ? sel1 : sel0;
        end
        wb_dat_o = wb_we_o ? (beat_q ? dat1 : dat0) : '0;
    end

    assert_err_drops_cyc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o && wb_err_i |=> !wb_cyc_o && !wb_stb_o)
        else $error("cycle still open after error");

    assert_rty_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o && wb_rty_i && !wb_err_i && wb_tag_o != TAG_IACK |=> wb_cyc_o && !wb_stb_o && !rsp_valid)
        else $error("memory retry not followed by a strobe gap");

    assert_iack_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o && wb_tag_o == TAG_IACK |-> wb_sel_o == 4'b0001 && !wb_we_o)
        else $error("acknowledge beat malformed");

    assert_rmw_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o && wb_tag_o == TAG_RMW |-> wb_lock_o)
        else $error("read-modify-write beat without lock");

    assert_single_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid)
        else $error("response pulse longer than one clock");

    assert_rsp_after_term_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(wb_stb_o && (wb_ack_i || wb_err_i || wb_rty_i)))
        else $error("response without a terminated beat");

    assert_stb_in_cyc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o |-> wb_cyc_o)
        else $error("strobe outside cycle");
endmodule

// File: tb/wbm_biu_tb_top.sv
`timescale 1ns/1ps
module wbm_biu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_hold = 1'b0;
    logic [1:0]  req_kind = '0, req_size = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata;
    logic        wb_cyc_o, wb_stb_o, wb_we_o, wb_lock_o;
    logic [1:0]  wb_tag_o;
    logic [29:0] wb_adr_o;
    logic [3:0]  wb_sel_o;
    logic [31:0] wb_dat_o;
    logic [31:0] wb_dat_i = '0;
    logic        wb_ack_i = 1'b0, wb_err_i = 1'b0, wb_rty_i = 1'b0;

    int n_chk = 0, n_bad = 0, n_cyc = 0;
    int scr[$];

    always #2 clk = ~clk;

    wbm_biu dut_i (.*);

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", n_cyc, 150000);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // memory content model: byte at a byte address
    function automatic logic [7:0] memb(input logic [31:0] a);
        return a[7:0] ^ 8'hA5 ^ a[15:8];
    endfunction

    // called at a falling edge, returns at the falling edge showing the response
    task automatic run_req(input logic [1:0] k, input logic [1:0] sz, input logic [31:0] a,
                           input logic [31:0] wd, input bit hold);
        logic [29:0] ea[4];
        logic [3:0]  es[4];
        logic [31:0] ed[4];
        bit          ew[4];
        logic [31:0] er = '0, m;
        int nb = 0, n, bi = 0, wait_n = 0, guard = 0, t;
        bit fresh = 1, done = 0, gap = 0;
        logic [1:0] exp_st = 2'd0;
        if (k == 2'd3) begin
            nb = 1; ea[0] = {27'h7FFFFFF, a[2:0]}; es[0] = 4'b0001; ew[0] = 0; ed[0] = '0;
            er = {24'h0, memb({ea[0], 2'b11})};
        end else if (k == 2'd2) begin
            nb = 2;
            ea[0] = a[31:2]; es[0] = 4'b1000 >> a[1:0]; ew[0] = 0; ed[0] = '0;
            ea[1] = a[31:2]; es[1] = es[0]; ew[1] = 1;
            ed[1] = {24'h0, memb(a) | 8'h80} << (8 * (3 - int'(a[1:0])));
            er = {24'h0, memb(a)};
        end else begin
            n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
            for (int i = 0; i < n; i++) begin
                logic [31:0] ai;
                int ln;
                ai = a + i;
                ln = int'(ai[1:0]);
                if (nb == 0 || ea[nb-1] != ai[31:2]) begin
                    ea[nb] = ai[31:2]; es[nb] = '0; ed[nb] = '0; ew[nb] = (k == 2'd1); nb++;
                end
                es[nb-1][3-ln] = 1'b1;
                ed[nb-1][8*(3-ln) +: 8] = wd[8*(n-1-i) +: 8];
                er = (er << 8) | {24'h0, memb(ai)};
            end
        end
        chk(req_ready == 1'b1, "R10 ready before request", {31'h0, req_ready}, 32'h1);
        req_valid = 1; req_kind = k; req_size = sz; req_addr = a; req_wdata = wd; req_hold = hold;
        @(negedge clk);
        req_valid = 0; req_hold = 0;
        while (!done && guard < 300) begin
            guard++;
            wb_ack_i = 0; wb_err_i = 0; wb_rty_i = 0;
            if (rsp_valid) begin
                done = 1;
                chk(rsp_status == exp_st, "R4 R7 response status", {30'h0, rsp_status}, {30'h0, exp_st});
                if (exp_st == 2'd0 && k != 2'd1)
                    chk(rsp_rdata == er, "R2 R6 R8 response data", rsp_rdata, er);
                if (exp_st == 2'd0)
                    chk(bi == nb, "R2 beat count", bi, nb);
                chk(wb_cyc_o == (hold && exp_st == 2'd0 && k < 2'd2), "R9 R4 cycle after response",
                    {31'h0, wb_cyc_o}, {31'h0, hold && exp_st == 2'd0 && k < 2'd2});
                chk(!wb_stb_o, "R10 strobe low at response", {31'h0, wb_stb_o}, 32'h0);
            end else begin
                chk(wb_cyc_o, "R10 cycle held in flight", {31'h0, wb_cyc_o}, 32'h1);
                chk(wb_lock_o == (k == 2'd2), "R8 lock level", {31'h0, wb_lock_o}, {31'h0, k == 2'd2});
                if (gap) begin
                    chk(!wb_stb_o, "R5 strobe gap after retry", {31'h0, wb_stb_o}, 32'h0);
                    gap = 0;
                end
                if (wb_stb_o) begin
                    if (fresh) begin
                        m = {{8{es[bi][3]}}, {8{es[bi][2]}}, {8{es[bi][1]}}, {8{es[bi][0]}}};
                        chk(wb_adr_o == ea[bi], "R1 R2 R6 beat address", {2'b0, wb_adr_o}, {2'b0, ea[bi]});
                        chk(wb_sel_o == es[bi], "R1 R2 byte selects", {28'h0, wb_sel_o}, {28'h0, es[bi]});
                        chk(wb_we_o == ew[bi], "R3 R8 write enable", {31'h0, wb_we_o}, {31'h0, ew[bi]});
                        chk(wb_tag_o == ((k == 2'd2) ? 2'd1 : (k == 2'd3) ? 2'd2 : 2'd0), "R6 R8 cycle tag",
                            {30'h0, wb_tag_o}, {30'h0, (k == 2'd2) ? 2'd1 : (k == 2'd3) ? 2'd2 : 2'd0});
                        if (ew[bi])
                            chk((wb_dat_o & m) == ed[bi], "R3 R8 write lanes", wb_dat_o & m, ed[bi]);
                        fresh = 0;
                        wait_n = $urandom_range(0, 2);
                    end
                    if (wait_n > 0) begin
                        wait_n--;
                    end else begin
                        t = (scr.size() > 0) ? scr.pop_front() : 0;
                        for (int ln = 0; ln < 4; ln++)
                            wb_dat_i[8*(3-ln) +: 8] = memb({wb_adr_o, 2'(ln)});
                        if (t == 1) begin
                            wb_err_i = 1; exp_st = (k == 2'd3) ? 2'd2 : 2'd1;
                        end else if (t == 2) begin
                            wb_rty_i = 1;
                            if (k == 2'd3) exp_st = 2'd3; else gap = 1;
                        end else begin
                            wb_ack_i = 1; bi++;
                        end
                        fresh = 1;
                    end
                end
                @(negedge clk);
            end
        end
        if (!done) chk(0, "R10 response missing", 32'h0, 32'h1);
    endtask

    task automatic quiet;
        @(negedge clk);
        chk(!rsp_valid, "R10 single response pulse", {31'h0, rsp_valid}, 32'h0);
        chk(!wb_cyc_o, "R9 cycle dropped when idle", {31'h0, wb_cyc_o}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!wb_cyc_o && !wb_stb_o && !wb_lock_o, "R11 bus idle in reset", {29'h0, wb_cyc_o, wb_stb_o, wb_lock_o}, 32'h0);
        chk(!rsp_valid && req_ready, "R11 handshake in reset", {30'h0, rsp_valid, req_ready}, 32'h1);
        rst_n = 1;
        @(negedge clk);
        // R1 aligned and single-lane reads
        run_req(2'd0, 2'd2, 32'h0000_0100, '0, 0); quiet();
        for (int o = 0; o < 4; o++) begin run_req(2'd0, 2'd0, 32'h0000_0240 + o, '0, 0); quiet(); end
        run_req(2'd0, 2'd1, 32'h0000_0302, '0, 0); quiet();
        // R3 writes
        run_req(2'd1, 2'd1, 32'h0000_0402, 32'h0000_BEEF, 0); quiet();
        run_req(2'd1, 2'd2, 32'h0000_0500, 32'h1234_5678, 0); quiet();
        run_req(2'd1, 2'd0, 32'h0000_0601, 32'h0000_00C3, 0); quiet();
        // R2 boundary crossing
        run_req(2'd0, 2'd1, 32'h0000_0703, '0, 0); quiet();
        for (int o = 1; o < 4; o++) begin run_req(2'd0, 2'd2, 32'h0000_0810 + o, '0, 0); quiet(); end
        run_req(2'd1, 2'd2, 32'h0000_0923, 32'hA1B2_C3D4, 0); quiet();
        // R4 errors
        scr = '{1}; run_req(2'd0, 2'd2, 32'h0000_0A00, '0, 1); quiet();
        scr = '{0, 1}; run_req(2'd0, 2'd2, 32'h0000_0B02, '0, 0); quiet();
        // R5 retries
        scr = '{2, 0}; run_req(2'd0, 2'd1, 32'h0000_0C00, '0, 0); quiet();
        scr = '{0, 2, 2, 0}; run_req(2'd1, 2'd2, 32'h0000_0D01, 32'h0BAD_F00D, 0); quiet();
        // R6 R7 interrupt acknowledge
        run_req(2'd3, 2'd0, 32'h0000_0005, '0, 0); quiet();
        scr = '{1}; run_req(2'd3, 2'd0, 32'h0000_0002, '0, 0); quiet();
        scr = '{2}; run_req(2'd3, 2'd0, 32'h0000_0007, '0, 1); quiet();
        // R8 test-and-set
        run_req(2'd2, 2'd2, 32'h0000_0E13, '0, 0); quiet();
        scr = '{1}; run_req(2'd2, 2'd0, 32'h0000_0E20, '0, 0); quiet();
        scr = '{0, 2, 0}; run_req(2'd2, 2'd0, 32'h0000_0E31, '0, 0); quiet();
        // R9 held block sequence, continued back to back
        run_req(2'd0, 2'd2, 32'h0000_1000, '0, 1);
        run_req(2'd0, 2'd2, 32'h0000_1004, '0, 1);
        run_req(2'd1, 2'd2, 32'h0000_1008, 32'h5566_7788, 1);
        run_req(2'd0, 2'd2, 32'h0000_100C, '0, 0); quiet();
        run_req(2'd1, 2'd1, 32'h0000_1100, 32'h0000_4242, 1); quiet();
        // mixed patterns with random terminations
        for (int r = 0; r < 60; r++) begin
            logic [31:0] ra;
            ra = $urandom & 32'h0000_3FFF;
            scr = {};
            for (int j = 0; j < 3; j++) scr.push_back(($urandom_range(0, 9) == 0) ? 1 : ($urandom_range(0, 5) == 0) ? 2 : 0);
            run_req(2'($urandom_range(0, 1)), 2'($urandom_range(0, 2)), ra, $urandom, 0); quiet();
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule